// File: doc/BRIEF.md
# I2C Serial Clock Phase Divider

This block derives the serial clock of an I2C master from a faster functional clock. A 32-bit divider word carries two 16-bit counts, one for the low phase and one for the high phase of SCL. The low phase lasts 8·(low+1) functional clocks and the high phase lasts 8·(high+1), so a full SCL period is 8·(low+1+high+1) clocks. The shortest period is 16 clocks, with both counts at zero. Software chooses the counts, usually splitting an even total equally and giving the extra unit to the high count when the total is odd. The block takes no part in that choice.

Each phase is cut into four equal quarters of 2·(count+1) clocks. A one-cycle strobe marks the first cycle of every quarter, and a quarter index and phase flags travel with it. A bus engine can then place START, STOP and data transitions at fixed points inside a phase. A period runs only while the block is enabled and a run request is present. The run request is sampled when the block is idle and at every period end. The divider word is captured only at the edge that opens a low phase, so a period never mixes two settings. Dropping the enable stops everything at the next edge and releases SCL high.

Top module: `scl_phase_divider`

## Requirements
- R1: Out of reset, and while `enable` is low, `sclOut` is 1, `lowPhase` and `highPhase` are 0 and `quarterStrobe` never pulses.
- R2: The low-phase count is taken from `divReg[15:0]` and the high-phase count from `divReg[31:16]`.
- R3: While running, SCL is low (`sclOut`=0, `lowPhase`=1) for exactly 8·(low+1) clocks. It is then high (`highPhase`=1) for exactly 8·(high+1) clocks, and `sclOut` always equals the inverse of `lowPhase`.
- R4: Each phase has four quarters, indexed 0,1,2,3 on `quarterIdx`. `quarterStrobe` is high for exactly the first cycle of each quarter, and successive strobes within a phase are 2·(count+1) clocks apart.
- R5: The divider word is sampled only at the edge that starts a low phase. A change applied at any other time, including the cycle just before a period boundary, first affects the period that begins at the next boundary.
- R6: `runReq` is sampled at the edge that would start a new period. If it is low there, the running period completes and the block goes idle with `sclOut`=1 and no further strobes.
- R7: When `enable` is low at a clock edge, the block is idle from the following cycle, whatever phase it was in. With `runReq` high, a new period starts from quarter 0 of the low phase once `enable` returns.
- R8: With both counts zero, the period is 16 clocks and every quarter lasts 2 clocks.
- R9: While `runReq` stays high, a new low phase follows the last high quarter with no idle cycle. The low-phase quarter-0 strobe comes 2·(high+1) clocks after the previous strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle at once |
| runReq | input | 1 | Request to run SCL periods, sampled at period boundaries |
| divReg | input | 32 | Divider word: high count [31:16], low count [15:0] |
| sclOut | output | 1 | Serial clock level, 1 when idle |
| lowPhase | output | 1 | SCL low phase in progress |
| highPhase | output | 1 | SCL high phase in progress |
| quarterStrobe | output | 1 | One-cycle pulse at the first cycle of each quarter |
| quarterIdx | output | 2 | Index of the current quarter within its phase |

## Verification
Two things can happen on the same edge: the end of a period, and a change of the divider word or of the run request. The bench provokes this by changing `divReg`, and later dropping `runReq`, at the falling edge just before a boundary edge. The new counts must govern the period opened by that edge, and the dropped request must leave the block idle after the current period. The scoreboard judges every strobe by its phase, index and spacing, so a value captured one edge late, or a period started or skipped wrongly, shows up as a gap or an unexpected pulse.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Commands from the phase control to the tick datapath
  typedef struct packed {
    logic clearAll;     // zero the tick counter and the captured counts
    logic loadDiv;      // capture the divider word, restart the tick counter
    logic restartTick;  // restart the tick counter for a new quarter
  } div_cmd_t;

endpackage

// File: rtl/scl_div_datapath.sv
module scl_div_datapath
  import scl_div_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  div_cmd_t           cmd,
  input  logic [2*DIV_W-1:0] divReg,
  input  logic               selHigh,
  output logic               quarterDone
);

  localparam int TICK_W = DIV_W + 1;

  logic [DIV_W-1:0]  lowLat;
  logic [DIV_W-1:0]  highLat;
  logic [TICK_W-1:0] tickCnt;
  logic [DIV_W-1:0]  lowField;
  logic [DIV_W-1:0]  highField;
  logic [TICK_W-1:0] quarterLast;

  // Field split of the divider word
  assign lowField  = divReg[DIV_W-1:0];
  assign highField = divReg[2*DIV_W-1:DIV_W];

  // A quarter lasts 2*(n+1) clocks, so its last tick is 2n+1
  assign quarterLast = {(selHigh ? highLat : lowLat), 1'b1};
  assign quarterDone = (tickCnt == quarterLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowLat  <= '0;
      highLat <= '0;
      tickCnt <= '0;
    end else if (cmd.clearAll) begin
      lowLat  <= '0;
      highLat <= '0;
      tickCnt <= '0;
    end else if (cmd.loadDiv) begin
      lowLat  <= lowField;
      highLat <= highField;
      tickCnt <= '0;
    end else if (cmd.restartTick) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tickCnt <= quarterLast); // R3

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.loadDiv && !cmd.clearAll) |=> ($stable(lowLat) && $stable(highLat))); // R5

endmodule

// File: rtl/scl_div_control.sv
module scl_div_control
  import scl_div_pkg::*;
#(
  parameter int QUARTERS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        runReq,
  input  logic                        quarterDone,
  output phase_e                      phase,
  output logic [$clog2(QUARTERS)-1:0] qIdx,
  output logic                        qStrobe,
  output div_cmd_t                    cmd,
  output logic                        selHigh
);

  localparam int IDX_W = $clog2(QUARTERS);
  localparam logic [IDX_W-1:0] LAST_Q = IDX_W'(QUARTERS - 1);

  phase_e           nPhase;
  logic [IDX_W-1:0] nIdx;
  logic             nStrobe;

  assign selHigh = (phase == PH_HIGH);

  always_comb begin
    nPhase  = phase;
    nIdx    = qIdx;
    nStrobe = 1'b0;
    cmd     = '0;
    if (!enable) begin
      nPhase       = PH_IDLE;
      nIdx         = '0;
      cmd.clearAll = 1'b1;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (runReq) begin
            nPhase      = PH_LOW;
            nIdx        = '0;
            nStrobe     = 1'b1;
            cmd.loadDiv = 1'b1;
          end else begin
            cmd.clearAll = 1'b1;
          end
        end
        PH_LOW, PH_HIGH: begin
          if (quarterDone) begin
            if (qIdx != LAST_Q) begin
              nIdx            = qIdx + 1'b1;
              nStrobe         = 1'b1;
              cmd.restartTick = 1'b1;
            end else if (phase == PH_LOW) begin
              nPhase          = PH_HIGH;
              nIdx            = '0;
              nStrobe         = 1'b1;
              cmd.restartTick = 1'b1;
            end else if (runReq) begin
              nPhase      = PH_LOW;
              nIdx        = '0;
              nStrobe     = 1'b1;
              cmd.loadDiv = 1'b1;
            end else begin
              nPhase       = PH_IDLE;
              nIdx         = '0;
              cmd.clearAll = 1'b1;
            end
          end
        end
        default: begin
          nPhase       = PH_IDLE;
          nIdx         = '0;
          cmd.clearAll = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      qIdx    <= '0;
      qStrobe <= 1'b0;
    end else begin
      phase   <= nPhase;
      qIdx    <= nIdx;
      qStrobe <= nStrobe;
    end
  end

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == PH_IDLE && !qStrobe)); // R7

  AST_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase == PH_LOW && qIdx == LAST_Q && quarterDone)
      |=> (phase == PH_HIGH && qIdx == '0 && qStrobe)); // R3

  AST_QUARTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase != PH_IDLE && !quarterDone) |=> ($stable(qIdx) && !qStrobe)); // R4

  AST_STOP_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !runReq && phase == PH_HIGH && qIdx == LAST_Q && quarterDone)
      |=> (phase == PH_IDLE)); // R6

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && runReq && phase == PH_HIGH && qIdx == LAST_Q && quarterDone)
      |=> (phase == PH_LOW && qStrobe)); // R9

endmodule

// File: rtl/scl_phase_divider.sv
module scl_phase_divider
  import scl_div_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int QUARTERS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        runReq,
  input  logic [2*DIV_W-1:0]          divReg,
  output logic                        sclOut,
  output logic                        lowPhase,
  output logic                        highPhase,
  output logic                        quarterStrobe,
  output logic [$clog2(QUARTERS)-1:0] quarterIdx
);

  phase_e   phase;
  div_cmd_t cmd;
  logic     quarterDone;
  logic     selHigh;

  scl_div_control #(.QUARTERS(QUARTERS)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .runReq      (runReq),
    .quarterDone (quarterDone),
    .phase       (phase),
    .qIdx        (quarterIdx),
    .qStrobe     (quarterStrobe),
    .cmd         (cmd),
    .selHigh     (selHigh)
  );

  scl_div_datapath #(.DIV_W(DIV_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .divReg      (divReg),
    .selHigh     (selHigh),
    .quarterDone (quarterDone)
  );

  assign lowPhase  = (phase == PH_LOW);
  assign highPhase = (phase == PH_HIGH);
  assign sclOut    = (phase != PH_LOW);

  AST_SCL_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sclOut && !quarterStrobe && !highPhase)); // R1

endmodule

// File: tb/scl_phase_divider_tb.sv
`timescale 1ns/1ps
module scl_phase_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        runReq = 1'b0;
  logic [31:0] divReg = '0;
  logic        sclOut, lowPhase, highPhase, quarterStrobe;
  logic [1:0]  quarterIdx;

  always #2 clk = ~clk;  // 250 MHz

  scl_phase_divider dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .runReq(runReq), .divReg(divReg),
    .sclOut(sclOut), .lowPhase(lowPhase), .highPhase(highPhase),
    .quarterStrobe(quarterStrobe), .quarterIdx(quarterIdx)
  );

  typedef struct {
    bit    hi;
    int    idx;
    int    gap;   // -1: spacing not judged
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   monOn   = 0;
  bit   summaryDone = 0;
  int   cycle = 0;
  int   lastStrobe = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Push the eight strobes of one period
  task automatic pushPeriod(input int lo, input int hi, input int prevHi, input string scen);
    exp_t e;
    for (int q = 0; q < 4; q++) begin
      e.hi = 0; e.idx = q;
      if (q == 0) begin
        e.gap = (prevHi < 0) ? -1 : 2 * (prevHi + 1);
        e.tag = {"R9 ", scen};
      end else begin
        e.gap = 2 * (lo + 1);
        e.tag = {"R4 ", scen};
      end
      expQ.push_back(e);
    end
    for (int q = 0; q < 4; q++) begin
      e.hi = 1; e.idx = q;
      if (q == 0) begin
        e.gap = 2 * (lo + 1);
        e.tag = {"R3 ", scen};
      end else begin
        e.gap = 2 * (hi + 1);
        e.tag = {"R4 ", scen};
      end
      expQ.push_back(e);
    end
  endtask

  // Monitor: sample away from the rising edge
  always @(negedge clk) begin
    cycle++;
    if (monOn) begin
      check(sclOut == !lowPhase, "R3", "sclOut vs lowPhase", sclOut, !lowPhase);
      check(!(lowPhase && highPhase), "R3", "phase flags exclusive", lowPhase + highPhase, 1);
      if (quarterStrobe) begin
        if (expQ.size() == 0) begin
          check(0, "R6", "unexpected strobe at quarter", quarterIdx, -1);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(highPhase == e.hi && lowPhase == !e.hi, e.tag, "strobe phase", highPhase, e.hi);
          check(quarterIdx == e.idx, e.tag, "quarter index", quarterIdx, e.idx);
          if (e.gap >= 0)
            check(cycle - lastStrobe == e.gap, e.tag, "strobe spacing", cycle - lastStrobe, e.gap);
        end
        lastStrobe = cycle;
      end
    end
  end

  task automatic waitIdle(input string tag);
    for (int i = 0; i < 4000 && expQ.size() != 0; i++) @(negedge clk);
    check(expQ.size() == 0, tag, "expected strobes left", expQ.size(), 0);
    repeat (40) @(negedge clk);
    check(sclOut == 1'b1 && !lowPhase && !highPhase, tag, "idle after run", sclOut, 1);
  endtask

  // Run a number of periods with fixed counts, drop runReq mid last period
  task automatic runScen(input int lo, input int hi, input int periods, input string scen);
    int t;
    t = 8 * (lo + hi + 2);
    for (int p = 0; p < periods; p++) pushPeriod(lo, hi, (p == 0) ? -1 : hi, scen);
    @(negedge clk);
    divReg = {16'(hi), 16'(lo)};
    runReq = 1'b1;
    @(posedge clk);
    repeat ((periods - 1) * t + 3) @(posedge clk);
    @(negedge clk);
    runReq = 1'b0;
    waitIdle({"R6 ", scen});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclOut == 1'b1, "R1", "sclOut in reset", sclOut, 1);
    check(!lowPhase && !highPhase && !quarterStrobe, "R1", "flags in reset",
          lowPhase + highPhase + quarterStrobe, 0);
    rst_n = 1'b1;
    monOn = 1'b1;
    // R1: run request ignored while disabled (monitor flags any strobe)
    divReg = {16'd1, 16'd1};
    runReq = 1'b1;
    repeat (30) @(negedge clk);
    check(sclOut == 1'b1 && !lowPhase, "R1", "disabled with runReq", sclOut, 1);
    runReq = 1'b0;
    enable = 1'b1;
    repeat (5) @(negedge clk);

    // R2: distinct low and high counts, three periods
    runScen(2, 3, 3, "R2");
    // R8: fastest period
    runScen(0, 0, 2, "R8");
    runScen(5, 1, 2, "R2");

    // R5: write during a period applies to the next one
    begin
      pushPeriod(1, 1, -1, "R5");
      pushPeriod(0, 4, 1, "R5");
      @(negedge clk);
      divReg = {16'd1, 16'd1};
      runReq = 1'b1;
      @(posedge clk);
      repeat (5) @(posedge clk);
      @(negedge clk);
      divReg = {16'd4, 16'd0};
      repeat (30) @(posedge clk);
      @(negedge clk);
      runReq = 1'b0;
      waitIdle("R5");
    end

    // R5/R6 same-cycle: change counts and drop request just before boundaries
    begin
      pushPeriod(1, 0, -1, "R5");
      pushPeriod(0, 2, 0, "R5");
      @(negedge clk);
      divReg = {16'd0, 16'd1};   // period 24 clocks
      runReq = 1'b1;
      @(posedge clk);
      repeat (23) @(posedge clk);
      @(negedge clk);
      divReg = {16'd2, 16'd0};   // period 32 clocks, sampled at the next edge
      repeat (32) @(posedge clk);
      @(negedge clk);
      runReq = 1'b0;             // seen at the boundary edge
      waitIdle("R6");
    end

    // R7: enable dropped mid phase, then restored
    begin
      exp_t e;
      e.hi = 0; e.idx = 0; e.gap = -1; e.tag = "R7";
      expQ.push_back(e);
      @(negedge clk);
      divReg = {16'd3, 16'd3};
      runReq = 1'b1;
      @(posedge clk);
      repeat (5) @(posedge clk);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check(sclOut == 1'b1 && !lowPhase && !quarterStrobe, "R7", "idle after disable", sclOut, 1);
      repeat (20) @(negedge clk);
      check(expQ.size() == 0, "R7", "strobes before disable", expQ.size(), 0);
      check(sclOut == 1'b1, "R7", "held idle while disabled", sclOut, 1);
      pushPeriod(3, 3, -1, "R7");
      enable = 1'b1;
      @(posedge clk);
      repeat (3) @(posedge clk);
      @(negedge clk);
      runReq = 1'b0;
      waitIdle("R7");
    end

    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!summaryDone) begin
      summaryDone = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule